// File: doc/BRIEF.md
# Multichannel Acquisition Scan Sequencer

This block decides when the conversions of a multichannel sampling front end start. Software configures it through a small register write port. It picks one of four launch sources: an internal pacer, an active-low external clock, the output of an analog threshold comparator, or a host command. Each launch starts one scan. A scan is one or more single-cycle conversion-start pulses, and each pulse goes with a channel address. The gap between pulses inside a scan comes from one programmable interval. The gap between scans comes from a second interval.

An external or comparator launch can be set to run a burst of N scans instead of one. A sample counter ends acquisition after a programmed number of conversion events, whatever the depth of the downstream FIFO. A FIFO-full event sets a sticky overrun bit, and no conversion starts while that bit is set. Four sticky event flags (count reached, FIFO half, FIFO full, data read) are combined under a mask into one interrupt request.

Register map. Every register is written on wr_data at the given wr_addr:
- 0 control: [1:0] source (0 pacer, 1 external clock, 2 comparator, 3 host), [3:2] addressing (0 single, 1 simultaneous, 2 sequential, 3 random), [4] run, [5] burst.
- 1 conversion gap. 2 scan gap. 3 scan count. 4 sample limit. 5 interrupt mask [3:0]. 6 command. 7 channel select.

Top module: `acq_scan_seq`

## Requirements
- R1: After reset, conv_start, busy, overrun, irq_flags and irq are all zero.
- R2: Only the source chosen in control[1:0] launches a scan: 0 pacer, 1 external clock, 2 comparator, 3 host command. Launches from the other sources are ignored, and every launch needs control[4] (run) set.
- R3: The external clock is active low. A falling level first sampled at clock edge k gives its first conv_start in the cycle after edge k+2. A rising level launches nothing. The comparator launches on a rising level with the same latency.
- R4: Inside a scan, successive conversion starts are spaced (conversion gap + 2) cycles apart.
- R5: When burst (control[5]) is set, an external or comparator launch runs N scans, where N is the scan-count register and a value of 0 counts as 1. Consecutive scans are spaced (scan gap + 2) cycles from the last pulse of one scan to the first pulse of the next.
- R6: Addressing mode 0 gives one pulse per scan on the channel in register 7. Mode 1 gives one pulse on all channels with chan_addr 0. Mode 2 gives NCH pulses on channels 0 up to NCH-1. Mode 3 gives NCH pulses, each on the register-7 channel as it stands at that pulse. conv_start bit i belongs to channel i.
- R7: With a non-zero sample limit L, the L-th conversion event since the last control write ends acquisition, sets irq_flags[0] and clears run. A limit of 0 means no limit.
- R8: fifo_full while run or busy sets a sticky overrun. While overrun is set, no conv_start is issued. Command bit 2 clears overrun, and held conversions then resume.
- R9: irq_flags are sticky: [0] count reached, [1] fifo_half, [2] fifo_full, [3] data_rd. irq is high when any flag is set whose bit in the mask register is set. Command bit 3 clears the flags.
- R10: Command bit 1 (stop) ends the sequence after the current conversion and clears run. No further conv_start follows.
- R11: Command bit 0 launches one scan when the source is host.
- R12: In pacer mode, scans launch every (scan gap + 1) cycles while run is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DW | Register write data |
| ext_clk_n | input | 1 | External trigger clock, active low, asynchronous |
| cmp_in | input | 1 | Threshold comparator output, asynchronous |
| fifo_half | input | 1 | FIFO half-full flag |
| fifo_full | input | 1 | FIFO full flag |
| data_rd | input | 1 | Data-read event pulse |
| conv_start | output | NCH | Per-channel conversion start pulses |
| chan_addr | output | AW | Channel address of the current conversion |
| busy | output | 1 | A scan sequence is in progress |
| overrun | output | 1 | Sticky overrun status |
| irq_flags | output | 4 | Sticky event flags |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench targets the spacing arithmetic. A gap counter that is off by one shifts every measured interval by one cycle, both inside scans and between burst scans. It checks that a scan count of zero still gives exactly one scan; a design that wraps the count would run 255 scans or none. It measures the trigger latency and confirms that a rising external level is ignored, which catches a wrong edge polarity or an extra synchroniser stage. It also covers overrun holding a scan mid-way and resuming it, a stop that must not let a further pulse slip through, random mode picking up a channel change in the middle of a scan, and a pacer run that has to stop at exactly the programmed sample count.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {SRC_PACER = 2'd0, SRC_EXT = 2'd1, SRC_CMP = 2'd2, SRC_HOST = 2'd3} src_e;
  typedef enum logic [1:0] {AM_SINGLE = 2'd0, AM_SIMUL = 2'd1, AM_SEQ = 2'd2, AM_RANDOM = 2'd3} amode_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_CONV = 2'd1, ST_GAP = 2'd2, ST_SGAP = 2'd3} seq_st_e;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_CGAP  = 3'd1;
  localparam logic [2:0] RA_SGAP  = 3'd2;
  localparam logic [2:0] RA_NSCAN = 3'd3;
  localparam logic [2:0] RA_LIMIT = 3'd4;
  localparam logic [2:0] RA_MASK  = 3'd5;
  localparam logic [2:0] RA_CMD   = 3'd6;
  localparam logic [2:0] RA_CHSEL = 3'd7;

  localparam int FL_COUNT = 0;
  localparam int FL_HALF  = 1;
  localparam int FL_FULL  = 2;
  localparam int FL_READ  = 3;
  localparam int NFLAGS   = 4;
endpackage

// File: rtl/acq_sync_edge.sv
module acq_sync_edge #(
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic active_edge
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= IDLE_LVL;
      s2 <= IDLE_LVL;
      s3 <= IDLE_LVL;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign active_edge = (s2 != IDLE_LVL) && (s3 == IDLE_LVL);

  // R3: an edge pulse never lasts two cycles
  assert_edge_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active_edge |=> !active_edge);
endmodule

// File: rtl/acq_regs.sv
module acq_regs
  import acq_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 16,
  parameter int CW = 16,
  parameter int NW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          run_clr,
  input  logic          busy,
  input  logic          cnt_hit,
  input  logic          fifo_half,
  input  logic          fifo_full,
  input  logic          data_rd,
  output src_e          src,
  output amode_e        mode,
  output logic          run,
  output logic          burst,
  output logic [TW-1:0] conv_gap,
  output logic [TW-1:0] scan_gap,
  output logic [NW-1:0] nscan,
  output logic [CW-1:0] limit,
  output logic [AW-1:0] chsel,
  output logic          ctrl_wr,
  output logic          cmd_go,
  output logic          cmd_stop,
  output logic          overrun,
  output logic [NFLAGS-1:0] flags,
  output logic          irq
);
  logic [NFLAGS-1:0] mask;
  logic we_cgap, we_sgap, we_nscan, we_limit, we_mask, we_chsel, we_cmd;
  logic clr_ovr, clr_flags;
  logic run_n, ovr_n;
  logic [NFLAGS-1:0] flags_n, flag_set;

  assign ctrl_wr  = wr_en && (wr_addr == RA_CTRL);
  assign we_cgap  = wr_en && (wr_addr == RA_CGAP);
  assign we_sgap  = wr_en && (wr_addr == RA_SGAP);
  assign we_nscan = wr_en && (wr_addr == RA_NSCAN);
  assign we_limit = wr_en && (wr_addr == RA_LIMIT);
  assign we_mask  = wr_en && (wr_addr == RA_MASK);
  assign we_chsel = wr_en && (wr_addr == RA_CHSEL);
  assign we_cmd   = wr_en && (wr_addr == RA_CMD);

  assign cmd_go    = we_cmd && wr_data[0];
  assign cmd_stop  = we_cmd && wr_data[1];
  assign clr_ovr   = we_cmd && wr_data[2];
  assign clr_flags = we_cmd && wr_data[3];

  always_comb begin
    run_n = run;
    if (ctrl_wr) run_n = wr_data[4];
    else if (run_clr || cmd_stop) run_n = 1'b0;

    ovr_n = overrun;
    if (fifo_full && (run || busy)) ovr_n = 1'b1;
    else if (clr_ovr) ovr_n = 1'b0;

    flag_set = '0;
    flag_set[FL_COUNT] = cnt_hit;
    flag_set[FL_HALF]  = fifo_half;
    flag_set[FL_FULL]  = fifo_full;
    flag_set[FL_READ]  = data_rd;
    flags_n = (clr_flags ? '0 : flags) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= SRC_PACER;
      mode <= AM_SINGLE;
      burst <= 1'b0;
      run <= 1'b0;
      conv_gap <= '0;
      scan_gap <= '0;
      nscan <= '0;
      limit <= '0;
      mask <= '0;
      chsel <= '0;
      overrun <= 1'b0;
      flags <= '0;
    end else begin
      if (ctrl_wr) begin
        src   <= src_e'(wr_data[1:0]);
        mode  <= amode_e'(wr_data[3:2]);
        burst <= wr_data[5];
      end
      run <= run_n;
      if (we_cgap)  conv_gap <= wr_data[TW-1:0];
      if (we_sgap)  scan_gap <= wr_data[TW-1:0];
      if (we_nscan) nscan    <= wr_data[NW-1:0];
      if (we_limit) limit    <= wr_data[CW-1:0];
      if (we_mask)  mask     <= wr_data[NFLAGS-1:0];
      if (we_chsel) chsel    <= wr_data[AW-1:0];
      overrun <= ovr_n;
      flags   <= flags_n;
    end
  end

  assign irq = |(flags & mask);

  // R8: overrun stays set until the clear command
  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clr_ovr) |=> overrun);
  // R9: a raised data-read event is visible in the flags next cycle
  assert_read_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |=> flags[FL_READ]);
endmodule

// File: rtl/acq_pacer.sv
module acq_pacer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [TW-1:0] period,
  output logic          tick
);
  logic [TW-1:0] cnt, cnt_n;

  assign tick = enable && (cnt == '0);

  always_comb begin
    if (!enable)          cnt_n = '0;
    else if (cnt == '0)   cnt_n = period;
    else                  cnt_n = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  // R12: no pacer tick while disabled
  assert_pacer_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt == '0));
endmodule

// File: rtl/acq_seq.sv
module acq_seq
  import acq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 2,
  parameter int TW  = 16,
  parameter int CW  = 16,
  parameter int NW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           launch,
  input  logic           multi,
  input  amode_e         mode,
  input  logic [AW-1:0]  chsel,
  input  logic [TW-1:0]  conv_gap,
  input  logic [TW-1:0]  scan_gap,
  input  logic [NW-1:0]  nscan,
  input  logic [CW-1:0]  limit,
  input  logic           hold,
  input  logic           stop,
  input  logic           cnt_clr,
  output logic [NCH-1:0] conv_start,
  output logic [AW-1:0]  chan_addr,
  output logic           busy,
  output logic           cnt_hit
);
  localparam logic [AW-1:0] LAST_CH = AW'(NCH - 1);

  seq_st_e       st, st_n;
  logic [AW-1:0] idx, idx_n, last_idx;
  logic [TW-1:0] wt, wt_n;
  logic [NW-1:0] sl, sl_n;
  logic [CW-1:0] sc, sc_n;
  logic          fire;

  assign fire     = (st == ST_CONV) && !hold;
  assign busy     = (st != ST_IDLE);
  assign last_idx = (mode == AM_SEQ || mode == AM_RANDOM) ? LAST_CH : '0;

  always_comb begin
    unique case (mode)
      AM_SEQ:   chan_addr = idx;
      AM_SIMUL: chan_addr = '0;
      default:  chan_addr = chsel;
    endcase
  end

  for (genvar i = 0; i < NCH; i++) begin : g_start
    assign conv_start[i] = fire && ((mode == AM_SIMUL) || (chan_addr == AW'(i)));
  end

  always_comb begin
    st_n = st; idx_n = idx; wt_n = wt; sl_n = sl; sc_n = sc; cnt_hit = 1'b0;
    unique case (st)
      ST_IDLE: if (launch) begin
        st_n  = ST_CONV;
        idx_n = '0;
        sl_n  = (multi && nscan != '0) ? nscan : NW'(1);
      end
      ST_CONV: if (fire) begin
        sc_n = sc + 1'b1;
        if (limit != '0 && sc_n == limit) begin
          cnt_hit = 1'b1;
          st_n    = ST_IDLE;
        end else if (idx == last_idx) begin
          if (sl > NW'(1)) begin
            sl_n  = sl - 1'b1;
            wt_n  = scan_gap;
            idx_n = '0;
            st_n  = ST_SGAP;
          end else begin
            st_n = ST_IDLE;
          end
        end else begin
          idx_n = idx + 1'b1;
          wt_n  = conv_gap;
          st_n  = ST_GAP;
        end
      end
      default: begin
        if (wt == '0) st_n = ST_CONV;
        else          wt_n = wt - 1'b1;
      end
    endcase
    if (cnt_clr) sc_n = '0;
    if (stop)    st_n = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      idx <= '0;
      wt  <= '0;
      sl  <= '0;
      sc  <= '0;
    end else begin
      st  <= st_n;
      idx <= idx_n;
      wt  <= wt_n;
      sl  <= sl_n;
      sc  <= sc_n;
    end
  end

  // R4: two conversion starts are never back to back
  assert_min_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|conv_start) |=> !(|conv_start));
  // R8: overrun hold blocks every start
  assert_hold_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (conv_start == '0));
  // R10: stop leaves the sequencer idle
  assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !busy);
  // R7: reaching the limit ends the sequence
  assert_limit_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_hit |=> !busy);
endmodule

// File: rtl/acq_scan_seq.sv
module acq_scan_seq
  import acq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int TW  = 16,
  parameter int CW  = 16,
  parameter int NW  = 8,
  localparam int AW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2:0]     wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           ext_clk_n,
  input  logic           cmp_in,
  input  logic           fifo_half,
  input  logic           fifo_full,
  input  logic           data_rd,
  output logic [NCH-1:0] conv_start,
  output logic [AW-1:0]  chan_addr,
  output logic           busy,
  output logic           overrun,
  output logic [3:0]     irq_flags,
  output logic           irq
);
  logic rs1, rs2, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 <= 1'b0;
      rs2 <= 1'b0;
    end else begin
      rs1 <= 1'b1;
      rs2 <= rs1;
    end
  end
  assign rst_i = rs2;

  src_e          src;
  amode_e        mode;
  logic          run, burst, ctrl_wr, cmd_go, cmd_stop, cnt_hit;
  logic [TW-1:0] conv_gap, scan_gap;
  logic [NW-1:0] nscan;
  logic [CW-1:0] limit;
  logic [AW-1:0] chsel;
  logic          ext_edge, cmp_edge, pace_tick, launch, multi, src_hit;

  acq_regs #(.DW(DW), .TW(TW), .CW(CW), .NW(NW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run_clr(cnt_hit), .busy(busy), .cnt_hit(cnt_hit), .fifo_half(fifo_half),
    .fifo_full(fifo_full), .data_rd(data_rd), .src(src), .mode(mode), .run(run),
    .burst(burst), .conv_gap(conv_gap), .scan_gap(scan_gap), .nscan(nscan),
    .limit(limit), .chsel(chsel), .ctrl_wr(ctrl_wr), .cmd_go(cmd_go),
    .cmd_stop(cmd_stop), .overrun(overrun), .flags(irq_flags), .irq(irq));

  acq_sync_edge #(.IDLE_LVL(1'b1)) u_ext_sync (
    .clk(clk), .rst_n(rst_i), .din(ext_clk_n), .active_edge(ext_edge));

  acq_sync_edge #(.IDLE_LVL(1'b0)) u_cmp_sync (
    .clk(clk), .rst_n(rst_i), .din(cmp_in), .active_edge(cmp_edge));

  acq_pacer #(.TW(TW)) u_pacer (
    .clk(clk), .rst_n(rst_i), .enable(run && (src == SRC_PACER)),
    .period(scan_gap), .tick(pace_tick));

  always_comb begin
    unique case (src)
      SRC_PACER: src_hit = pace_tick;
      SRC_EXT:   src_hit = ext_edge;
      SRC_CMP:   src_hit = cmp_edge;
      default:   src_hit = cmd_go;
    endcase
  end
  assign launch = run && src_hit;
  assign multi  = burst && (src == SRC_EXT || src == SRC_CMP);

  acq_seq #(.NCH(NCH), .AW(AW), .TW(TW), .CW(CW), .NW(NW)) u_seq (
    .clk(clk), .rst_n(rst_i), .launch(launch), .multi(multi), .mode(mode),
    .chsel(chsel), .conv_gap(conv_gap), .scan_gap(scan_gap), .nscan(nscan),
    .limit(limit), .hold(overrun), .stop(cmd_stop), .cnt_clr(ctrl_wr),
    .conv_start(conv_start), .chan_addr(chan_addr), .busy(busy), .cnt_hit(cnt_hit));

  // R2: a scan starts only while run is set or a sequence is active
  assert_launch_run_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (!busy && !run) |=> !busy);
endmodule

// File: tb/acq_scan_seq_test.sv
module acq_scan_seq_test;
  localparam int NCH = 4;
  localparam int AW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic ext_clk_n = 1'b1, cmp_in = 1'b0, fifo_half = 1'b0, fifo_full = 1'b0, data_rd = 1'b0;
  logic [NCH-1:0] conv_start;
  logic [AW-1:0] chan_addr;
  logic busy, overrun, irq;
  logic [3:0] irq_flags;

  always #2.5 clk = ~clk;

  acq_scan_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_clk_n(ext_clk_n), .cmp_in(cmp_in), .fifo_half(fifo_half), .fifo_full(fifo_full),
    .data_rd(data_rd), .conv_start(conv_start), .chan_addr(chan_addr), .busy(busy),
    .overrun(overrun), .irq_flags(irq_flags), .irq(irq));

  int compared = 0, mismatched = 0;
  int cyc = 0;
  string cur_req = "R1";
  logic [AW+NCH-1:0] expq[$];
  int stamps[$];

  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (|conv_start)) begin
      stamps.push_back(cyc);
      compared++;
      if (expq.size() == 0) begin
        mismatched++;
        $display("FAIL %s unexpected start: got %h expected none", cur_req, {chan_addr, conv_start});
      end else begin
        logic [AW+NCH-1:0] e;
        e = expq.pop_front();
        if (e !== {chan_addr, conv_start}) begin
          mismatched++;
          $display("FAIL %s scan item: got %h expected %h", cur_req, {chan_addr, conv_start}, e);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push(input int ch, input logic [NCH-1:0] vec);
    expq.push_back({AW'(ch), vec});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(input string req);
    chk(expq.size() == 0, req, expq.size(), 0);
  endtask

  task automatic spacing(input string req, input int n, input int gap);
    chk(stamps.size() == n, req, stamps.size(), n);
    for (int i = 1; i < stamps.size(); i++)
      chk(stamps[i] - stamps[i-1] == gap, req, stamps[i] - stamps[i-1], gap);
  endtask

  // ctrl: src | mode<<2 | run<<4 | burst<<5
  function automatic logic [15:0] ctrl(input int s, input int m, input bit r, input bit b);
    return 16'(s | (m << 2) | (int'(r) << 4) | (int'(b) << 5));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    chk(conv_start == 0, "R1 conv_start", conv_start, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(overrun == 0, "R1 overrun", overrun, 0);
    chk(irq_flags == 0, "R1 flags", irq_flags, 0);
    chk(irq == 0, "R1 irq", irq, 0);

    // R11, R6, R4: host launch, sequential mode, conversion gap 3
    cur_req = "R11"; stamps.delete();
    wr(3'd1, 16'd3);
    wr(3'd0, ctrl(3, 2, 1, 0));
    for (int i = 0; i < NCH; i++) push(i, NCH'(1) << i);
    wr(3'd6, 16'h1);
    idle(40);
    drained("R6 sequential");
    spacing("R4 gap", 4, 5);

    // R6 simultaneous
    cur_req = "R6"; stamps.delete();
    wr(3'd0, ctrl(3, 1, 1, 0));
    push(0, 4'b1111);
    wr(3'd6, 16'h1);
    idle(10);
    drained("R6 simultaneous");

    // R6 single on channel 2
    wr(3'd7, 16'd2);
    wr(3'd0, ctrl(3, 0, 1, 0));
    push(2, 4'b0100);
    wr(3'd6, 16'h1);
    idle(10);
    drained("R6 single");

    // R6 random: channel changes mid-scan
    stamps.delete();
    wr(3'd1, 16'd6);
    wr(3'd7, 16'd3);
    wr(3'd0, ctrl(3, 3, 1, 0));
    push(3, 4'b1000); push(1, 4'b0010); push(1, 4'b0010); push(1, 4'b0010);
    wr(3'd6, 16'h1);
    wait (|conv_start);
    wr(3'd7, 16'd1);
    idle(40);
    drained("R6 random");

    // R3, R5: external falling edge, burst of 3, scan gap 4
    cur_req = "R5"; stamps.delete();
    wr(3'd7, 16'd1);
    wr(3'd2, 16'd4);
    wr(3'd3, 16'd3);
    wr(3'd0, ctrl(1, 0, 1, 1));
    for (int i = 0; i < 3; i++) push(1, 4'b0010);
    begin
      int c0;
      @(negedge clk);
      c0 = cyc;
      ext_clk_n = 1'b0;
      idle(40);
      chk(stamps.size() > 0 && stamps[0] == c0 + 3, "R3 latency",
          stamps.size() > 0 ? stamps[0] - c0 : -1, 3);
    end
    spacing("R5 burst", 3, 6);
    drained("R5 burst");
    stamps.delete();
    cur_req = "R3";
    ext_clk_n = 1'b1;
    idle(20);
    chk(stamps.size() == 0, "R3 rising ignored", stamps.size(), 0);

    // R5: scan count 0 counts as one scan
    cur_req = "R5"; stamps.delete();
    wr(3'd3, 16'd0);
    push(1, 4'b0010);
    ext_clk_n = 1'b0;
    idle(30);
    ext_clk_n = 1'b1;
    idle(10);
    chk(stamps.size() == 1, "R5 zero count", stamps.size(), 1);
    drained("R5 zero count");

    // R2: comparator source ignores ext and host launches
    cur_req = "R2"; stamps.delete();
    wr(3'd7, 16'd2);
    wr(3'd0, ctrl(2, 0, 1, 0));
    ext_clk_n = 1'b0; idle(10); ext_clk_n = 1'b1; idle(10);
    wr(3'd6, 16'h1);
    idle(10);
    chk(stamps.size() == 0, "R2 others ignored", stamps.size(), 0);
    push(2, 4'b0100);
    cmp_in = 1'b1;
    idle(15);
    cmp_in = 1'b0;
    idle(5);
    chk(stamps.size() == 1, "R2 comparator launch", stamps.size(), 1);
    drained("R2 comparator");

    // R12, R7, R9: pacer, scan gap 5, limit 4
    cur_req = "R12"; stamps.delete();
    wr(3'd2, 16'd5);
    wr(3'd4, 16'd4);
    wr(3'd5, 16'h1);
    wr(3'd7, 16'd0);
    for (int i = 0; i < 4; i++) push(0, 4'b0001);
    wr(3'd0, ctrl(0, 0, 1, 0));
    idle(60);
    spacing("R12 pacer period", 4, 6);
    drained("R7 limit");
    chk(busy == 0, "R7 stopped", busy, 0);
    chk(irq_flags[0] == 1, "R7 count flag", irq_flags[0], 1);
    chk(irq == 1, "R9 masked irq", irq, 1);
    wr(3'd6, 16'h8);
    idle(2);
    chk(irq == 0, "R9 cleared", irq, 0);
    wr(3'd4, 16'd0);

    // R8: overrun holds, clear resumes
    cur_req = "R8"; stamps.delete();
    wr(3'd1, 16'd3);
    wr(3'd0, ctrl(3, 2, 1, 0));
    @(negedge clk); fifo_full = 1'b1; @(negedge clk); fifo_full = 1'b0;
    idle(1);
    chk(overrun == 1, "R8 overrun set", overrun, 1);
    for (int i = 0; i < NCH; i++) push(i, NCH'(1) << i);
    wr(3'd6, 16'h1);
    idle(30);
    chk(stamps.size() == 0, "R8 suppressed", stamps.size(), 0);
    chk(overrun == 1, "R8 sticky", overrun, 1);
    wr(3'd6, 16'h4);
    idle(40);
    drained("R8 resume");
    chk(overrun == 0, "R8 cleared", overrun, 0);

    // R10: stop after first conversion
    cur_req = "R10"; stamps.delete();
    wr(3'd1, 16'd10);
    push(0, 4'b0001);
    wr(3'd6, 16'h1);
    wait (|conv_start);
    wr(3'd6, 16'h2);
    idle(40);
    chk(stamps.size() == 1, "R10 no further starts", stamps.size(), 1);
    chk(busy == 0, "R10 idle", busy, 0);
    drained("R10");

    // R9: flags and mask
    cur_req = "R9";
    wr(3'd6, 16'h8);
    wr(3'd5, 16'h2);
    @(negedge clk); fifo_half = 1'b1; @(negedge clk); fifo_half = 1'b0;
    chk(irq == 1, "R9 half irq", irq, 1);
    @(negedge clk); data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
    chk(irq_flags == 4'b1010, "R9 flags", irq_flags, 10);
    wr(3'd6, 16'h8);
    idle(1);
    chk(irq == 0 && irq_flags == 0, "R9 clear", irq_flags, 0);
    wr(3'd5, 16'h8);
    @(negedge clk); data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
    chk(irq == 1, "R9 read irq", irq, 1);
    wr(3'd5, 16'h0);
    idle(1);
    chk(irq == 0, "R9 masked off", irq, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule